// File: doc/BRIEF.md
# Oscillator Source Switch Sequencer

This controller moves the system clock between three oscillator sources (an untrimmed RC, a trimmed RC and a crystal) by driving the control side of a glitch-free clock multiplexer. The multiplexer itself lives elsewhere. A single request names the wanted source and may ask that RC calibration be skipped. The sequencer then powers the source, loads its trim code and arms the multiplexer input. Only after that does it move the select value, which it guards with a hold flag. When the sequence ends, it pulses `done` and reports error and untrimmed status.

Every trim code has to come from somewhere. For the trimmed RC the code is taken from the retained always-on copy, or failing that from the fuse copy, or failing that from an external calibrator. For the crystal, a calibration state machine is started with a key unless it already reports completion. Its final trim and its failure status are then carried back. Any move between the untrimmed RC and the crystal is split into two hops, with the trimmed RC as the middle stop.

Top module: `osc_switch_seq`

## Requirements
- R1: A request whose target equals the current select value changes no select, trim, ready or power output, leaves `sel_hold` at 1 and completes with `done`, `err`=0 and `untrimmed`=0.
- R2: The select value never changes directly between 2'b00 and 2'b10. Such a request first switches to 2'b01 with calibration skipped, then continues to the target.
- R3: When the select value changes to a source, that source's `mux_ready_b` bit is already 0 and its `src_pwr_en` bit is 1. Before that, the bit was driven 1 while the trim was loaded. Bit index equals the select encoding.
- R4: The select value changes only while `sel_hold` is 0. The order is: hold cleared, select written, hold set.
- R5: The trimmed-RC code is taken from `aon_rc_code` if `aon_rc_valid`=1. Otherwise it comes from `fuse_rc_code` if `fuse_rc_valid`=1. Otherwise it comes from `cal_code`, after `cal_req` has been raised and `cal_done` returned.
- R6: With skip set and neither valid bit set, the RC trim code is kept, `cal_req` is never raised, and `untrimmed` reads 1 after completion.
- R7: A trim code (RC or crystal) changes only while its hold output is 0. It is written together with its enable bit set, and its hold output is set again afterwards.
- R8: If `xfsm_done` is already 1, the crystal calibration is not restarted. Otherwise `xfsm_en` goes to 0 and then to the key value, and the sequencer waits for `xfsm_done`.
- R9: After a crystal switch, `xtal_trim_code` holds `xfsm_trim`, `xtal_trim_en`=1, and `err` equals `xfsm_fail`.
- R10: Select encodings are 2'b00 untrimmed RC, 2'b01 trimmed RC and 2'b10 crystal. A request for 2'b11 completes with `err`=1 and changes no select.
- R11: A wait on `cal_done` or `xfsm_done` that lasts TIMEOUT cycles ends the request with `err`=1 and no select change.
- R12: After reset: `sel`=2'b00, `sel_hold`=1, `mux_ready_b`=3'b110, `src_pwr_en`=3'b001, `busy`=0, `err`=0, RC trim code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_target | input | 2 | Wanted source encoding |
| req_skip_cal | input | 1 | Skip RC calibration when no stored code exists |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error status of the last request |
| untrimmed | output | 1 | Trimmed RC left with its old code |
| sel | output | 2 | Multiplexer select value |
| sel_hold | output | 1 | Select hold flag |
| src_pwr_en | output | 3 | Power enable per source |
| mux_ready_b | output | 3 | Active-low ready per multiplexer input |
| aon_rc_valid | input | 1 | Retained RC code valid |
| aon_rc_code | input | TRIM_W | Retained RC code |
| fuse_rc_valid | input | 1 | Fuse RC code valid |
| fuse_rc_code | input | TRIM_W | Fuse RC code |
| rc_trim_code | output | TRIM_W | RC trim register code |
| rc_trim_en | output | 1 | RC trim enable |
| rc_trim_hold | output | 1 | RC trim hold |
| cal_req | output | 1 | RC calibration request |
| cal_done | input | 1 | RC calibration finished |
| cal_code | input | TRIM_W | RC calibration result |
| xfsm_en | output | KEY_W | Crystal calibration enable word |
| xfsm_done | input | 1 | Crystal calibration done |
| xfsm_fail | input | 1 | Crystal calibration failed |
| xfsm_trim | input | TRIM_W | Crystal calibration result |
| xtal_trim_code | output | TRIM_W | Crystal trim register code |
| xtal_trim_en | output | 1 | Crystal trim enable |
| xtal_trim_hold | output | 1 | Crystal trim hold |

## Verification
The bench builds the block with TIMEOUT=12, TRIM_W=8 and key 8'hC3. The short timeout lets a silent calibrator drive the error path within a few dozen cycles. Bench models of the calibrator and the crystal state machine answer after fixed delays. The crystal done flag stays high between runs, so a second crystal switch exercises the no-restart path. Monitors on the select, hold, ready and trim outputs count every ordering violation over the whole run.

// File: rtl/osc_seq_pkg.sv
package osc_seq_pkg;
  localparam logic [1:0] SRC_RC  = 2'b00;
  localparam logic [1:0] SRC_RCT = 2'b01;
  localparam logic [1:0] SRC_XTL = 2'b10;

  typedef enum logic [1:0] {PICK_AON, PICK_FUSE, PICK_CAL, PICK_KEEP} rc_pick_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PREP, ST_PICK, ST_CAL, ST_XCLR, ST_XKEY, ST_XWAIT,
    ST_TCLR, ST_TWR, ST_TSET, ST_ARM, ST_SCLR, ST_SWR, ST_SSET, ST_FIN
  } seq_st_t;

  // next hop: a move between untrimmed RC and crystal stops on trimmed RC
  function automatic logic [1:0] hop_target(input logic [1:0] cur, input logic [1:0] tgt);
    if (tgt != SRC_RCT && cur != SRC_RCT && tgt != cur) return SRC_RCT;
    return tgt;
  endfunction

  function automatic rc_pick_t pick_rc_source(input logic aon_v, input logic fuse_v,
                                              input logic skip);
    if (aon_v)  return PICK_AON;
    if (fuse_v) return PICK_FUSE;
    if (skip)   return PICK_KEEP;
    return PICK_CAL;
  endfunction
endpackage

// File: rtl/osc_trim_slot.sv
module osc_trim_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_hold,
  input  logic         wr,
  input  logic         set_hold,
  input  logic [W-1:0] wr_code,
  output logic [W-1:0] code,
  output logic         en,
  output logic         hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
      en   <= 1'b0;
      hold <= 1'b1;
    end else begin
      if (clr_hold) hold <= 1'b0;
      if (set_hold) hold <= 1'b1;
      if (wr && !hold) begin
        code <= wr_code;
        en   <= 1'b1;
      end
    end
  end

  AST_TRIM_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |-> !$past(hold)); // R7
endmodule

// File: rtl/osc_wait_timer.sv
module osc_wait_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run)          cnt <= '0;
    else if (cnt != LIM_C)  cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LIM_C);

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM_C); // R11
endmodule

// File: rtl/osc_switch_seq.sv
module osc_switch_seq
  import osc_seq_pkg::*;
#(
  parameter int TRIM_W  = 8,
  parameter int KEY_W   = 8,
  parameter logic [KEY_W-1:0] XKEY = 8'hC3,
  parameter int TIMEOUT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_target,
  input  logic              req_skip_cal,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              untrimmed,
  output logic [1:0]        sel,
  output logic              sel_hold,
  output logic [2:0]        src_pwr_en,
  output logic [2:0]        mux_ready_b,
  input  logic              aon_rc_valid,
  input  logic [TRIM_W-1:0] aon_rc_code,
  input  logic              fuse_rc_valid,
  input  logic [TRIM_W-1:0] fuse_rc_code,
  output logic [TRIM_W-1:0] rc_trim_code,
  output logic              rc_trim_en,
  output logic              rc_trim_hold,
  output logic              cal_req,
  input  logic              cal_done,
  input  logic [TRIM_W-1:0] cal_code,
  output logic [KEY_W-1:0]  xfsm_en,
  input  logic              xfsm_done,
  input  logic              xfsm_fail,
  input  logic [TRIM_W-1:0] xfsm_trim,
  output logic [TRIM_W-1:0] xtal_trim_code,
  output logic              xtal_trim_en,
  output logic              xtal_trim_hold
);
  seq_st_t           st;
  logic [1:0]        step_tgt, final_tgt;
  logic              step_skip, final_skip;
  logic              dst_xtal;
  logic [TRIM_W-1:0] stage;
  logic              wait_run, wait_expired;
  logic              trim_clr, trim_wr, trim_set;
  rc_pick_t          rc_pick;

  assign rc_pick  = pick_rc_source(aon_rc_valid, fuse_rc_valid, step_skip);
  assign wait_run = (st == ST_CAL) || (st == ST_XWAIT);
  assign trim_clr = (st == ST_TCLR);
  assign trim_wr  = (st == ST_TWR);
  assign trim_set = (st == ST_TSET);
  assign busy     = (st != ST_IDLE);
  assign done     = (st == ST_FIN);
  assign cal_req  = (st == ST_CAL);

  osc_wait_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(wait_run), .expired(wait_expired));

  osc_trim_slot #(.W(TRIM_W)) u_rc_trim (
    .clk(clk), .rst_n(rst_n),
    .clr_hold(trim_clr && !dst_xtal), .wr(trim_wr && !dst_xtal),
    .set_hold(trim_set && !dst_xtal), .wr_code(stage),
    .code(rc_trim_code), .en(rc_trim_en), .hold(rc_trim_hold));

  osc_trim_slot #(.W(TRIM_W)) u_xtal_trim (
    .clk(clk), .rst_n(rst_n),
    .clr_hold(trim_clr && dst_xtal), .wr(trim_wr && dst_xtal),
    .set_hold(trim_set && dst_xtal), .wr_code(stage),
    .code(xtal_trim_code), .en(xtal_trim_en), .hold(xtal_trim_hold));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      step_tgt    <= SRC_RC;
      final_tgt   <= SRC_RC;
      step_skip   <= 1'b0;
      final_skip  <= 1'b0;
      dst_xtal    <= 1'b0;
      stage       <= '0;
      err         <= 1'b0;
      untrimmed   <= 1'b0;
      sel         <= SRC_RC;
      sel_hold    <= 1'b1;
      src_pwr_en  <= 3'b001;
      mux_ready_b <= 3'b110;
      xfsm_en     <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          err        <= 1'b0;
          untrimmed  <= 1'b0;
          final_tgt  <= req_target;
          final_skip <= req_skip_cal;
          if (req_target == 2'b11) begin
            err <= 1'b1;
            st  <= ST_FIN;
          end else if (req_target == sel) begin
            st <= ST_SSET;
          end else begin
            step_tgt  <= hop_target(sel, req_target);
            step_skip <= (hop_target(sel, req_target) != req_target) ? 1'b1 : req_skip_cal;
            st        <= ST_PREP;
          end
        end
        ST_PREP: begin
          mux_ready_b[step_tgt] <= 1'b1;
          src_pwr_en[step_tgt]  <= 1'b1;
          st <= ST_PICK;
        end
        ST_PICK: begin
          if (step_tgt == SRC_RC) begin
            st <= ST_ARM;
          end else if (step_tgt == SRC_RCT) begin
            dst_xtal <= 1'b0;
            unique case (rc_pick)
              PICK_AON:  begin stage <= aon_rc_code;  st <= ST_TCLR; end
              PICK_FUSE: begin stage <= fuse_rc_code; st <= ST_TCLR; end
              PICK_CAL:  st <= ST_CAL;
              default:   begin untrimmed <= 1'b1; st <= ST_ARM; end
            endcase
          end else begin
            dst_xtal <= 1'b1;
            if (xfsm_done) begin
              stage <= xfsm_trim;
              err   <= xfsm_fail;
              st    <= ST_TCLR;
            end else begin
              st <= ST_XCLR;
            end
          end
        end
        ST_CAL: begin
          if (cal_done) begin
            stage <= cal_code;
            st    <= ST_TCLR;
          end else if (wait_expired) begin
            err <= 1'b1;
            st  <= ST_FIN;
          end
        end
        ST_XCLR: begin xfsm_en <= '0;   st <= ST_XKEY;  end
        ST_XKEY: begin xfsm_en <= XKEY; st <= ST_XWAIT; end
        ST_XWAIT: begin
          if (xfsm_done) begin
            stage <= xfsm_trim;
            err   <= xfsm_fail;
            st    <= ST_TCLR;
          end else if (wait_expired) begin
            err <= 1'b1;
            st  <= ST_FIN;
          end
        end
        ST_TCLR: st <= ST_TWR;
        ST_TWR:  st <= ST_TSET;
        ST_TSET: st <= ST_ARM;
        ST_ARM: begin
          mux_ready_b[step_tgt] <= 1'b0;
          st <= ST_SCLR;
        end
        ST_SCLR: begin sel_hold <= 1'b0; st <= ST_SWR; end
        ST_SWR:  begin sel <= step_tgt;  st <= ST_SSET; end
        ST_SSET: begin
          sel_hold <= 1'b1;
          if (sel != final_tgt) begin
            step_tgt  <= final_tgt;
            step_skip <= final_skip;
            st        <= ST_PREP;
          end else begin
            st <= ST_FIN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_SEL_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel) |-> !$past(sel_hold)); // R4
  AST_NO_DIRECT_HOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel) |-> (sel == SRC_RCT || $past(sel) == SRC_RCT)); // R2
  AST_READY_BEFORE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel) |-> (!mux_ready_b[sel] && src_pwr_en[sel])); // R3
  AST_KEY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (xfsm_en == XKEY && !$stable(xfsm_en)) |-> $past(xfsm_en) == '0); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1
  AST_BAD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && req_valid && req_target == 2'b11) |=> (done && err && $stable(sel))); // R10
endmodule

// File: tb/osc_switch_seq_tb.sv
module osc_switch_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;
  localparam logic [7:0] KEY = 8'hC3;
  localparam logic [7:0] AON_C = 8'h3C, FUSE_C = 8'h5A, CAL_C = 8'h77, XT_C = 8'h2D;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_skip_cal = 1'b0;
  logic [1:0] req_target = 2'b00;
  logic busy, done, err, untrimmed, sel_hold, rc_trim_en, rc_trim_hold, cal_req;
  logic xtal_trim_en, xtal_trim_hold;
  logic [1:0] sel;
  logic [2:0] src_pwr_en, mux_ready_b;
  logic aon_rc_valid = 1'b0, fuse_rc_valid = 1'b0, xfsm_fail = 1'b0, cal_enable = 1'b1;
  logic [TW-1:0] rc_trim_code, xtal_trim_code;
  logic [7:0] xfsm_en;
  logic cal_done, xfsm_done;
  int cal_cnt, x_cnt, key_writes, cal_starts;
  int viol_hold, viol_hop, viol_rdy, viol_trim;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_switch_seq #(.TRIM_W(TW), .KEY_W(8), .XKEY(KEY), .TIMEOUT(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
    .req_skip_cal(req_skip_cal), .busy(busy), .done(done), .err(err),
    .untrimmed(untrimmed), .sel(sel), .sel_hold(sel_hold), .src_pwr_en(src_pwr_en),
    .mux_ready_b(mux_ready_b), .aon_rc_valid(aon_rc_valid), .aon_rc_code(AON_C),
    .fuse_rc_valid(fuse_rc_valid), .fuse_rc_code(FUSE_C), .rc_trim_code(rc_trim_code),
    .rc_trim_en(rc_trim_en), .rc_trim_hold(rc_trim_hold), .cal_req(cal_req),
    .cal_done(cal_done), .cal_code(CAL_C), .xfsm_en(xfsm_en), .xfsm_done(xfsm_done),
    .xfsm_fail(xfsm_fail), .xfsm_trim(XT_C), .xtal_trim_code(xtal_trim_code),
    .xtal_trim_en(xtal_trim_en), .xtal_trim_hold(xtal_trim_hold));

  // calibrator and crystal FSM models
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_cnt <= 0; cal_done <= 1'b0; x_cnt <= 0; xfsm_done <= 1'b0;
    end else begin
      cal_cnt  <= cal_req ? cal_cnt + 1 : 0;
      cal_done <= cal_req && cal_enable && (cal_cnt >= 3);
      if (xfsm_en == 8'h00) begin
        x_cnt <= 0; xfsm_done <= 1'b0;
      end else if (xfsm_en == KEY && !xfsm_done) begin
        x_cnt <= x_cnt + 1;
        if (x_cnt == 4) xfsm_done <= 1'b1;
      end
    end
  end

  // ordering monitors, sampled away from the active edge
  logic [1:0] p_sel; logic p_hold, p_cal, p_rch; logic [7:0] p_xen, p_rc;
  always @(negedge clk) begin
    if (!rst_n) begin
      p_sel = 2'b00; p_hold = 1'b1; p_cal = 1'b0; p_xen = 8'h00; p_rc = 8'h00; p_rch = 1'b1;
      key_writes = 0; cal_starts = 0; viol_hold = 0; viol_hop = 0; viol_rdy = 0; viol_trim = 0;
    end else begin
      if (sel != p_sel) begin
        if (p_hold) viol_hold++;
        if (sel != 2'b01 && p_sel != 2'b01) viol_hop++;
        if (mux_ready_b[sel] || !src_pwr_en[sel]) viol_rdy++;
      end
      if (rc_trim_code != p_rc && p_rch) viol_trim++;
      if (xfsm_en == KEY && p_xen == 8'h00) key_writes++;
      if (cal_req && !p_cal) cal_starts++;
      p_sel = sel; p_hold = sel_hold; p_cal = cal_req; p_xen = xfsm_en;
      p_rc = rc_trim_code; p_rch = rc_trim_hold;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic run_req(input logic [1:0] tgt, input logic skip);
    bit seen = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_target = tgt; req_skip_cal = skip;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk(seen, "R1 done seen", 32'(seen), 32'd1);
  endtask

  typedef struct packed {
    logic [1:0] tgt; logic skip; logic aon; logic fuse; logic xf;
    logic [1:0] esel; logic eerr; logic euntr; logic [7:0] erc;
  } vec_t;
  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00},  // R1 same source
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1, 8'h00},  // R2 R6 R9 via trimmed RC
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 8'h00},  // R1 already crystal
    '{2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 8'h5A},  // R2 R5 fuse code
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 8'h77},  // R5 calibration
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 8'h77},  // R1
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h77},  // direct down
    '{2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 8'h3C},  // R5 retained first
    '{2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 8'h3C},  // R10 bad target
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 8'h3C}   // R8 R9 no rerun, fail
  };

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(sel == 2'b00 && sel_hold, "R12 select", {sel, sel_hold}, 3'b001);
    chk(mux_ready_b == 3'b110, "R12 ready", 32'(mux_ready_b), 32'h6);
    chk(src_pwr_en == 3'b001, "R12 power", 32'(src_pwr_en), 32'h1);
    chk(!busy && !err && rc_trim_code == 8'h00, "R12 status", {busy, err, rc_trim_code}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      aon_rc_valid = VT[v].aon; fuse_rc_valid = VT[v].fuse; xfsm_fail = VT[v].xf;
      run_req(VT[v].tgt, VT[v].skip);
      chk(sel == VT[v].esel, $sformatf("R2 R10 sel v%0d", v), 32'(sel), 32'(VT[v].esel));
      chk(err == VT[v].eerr, $sformatf("R9 R10 err v%0d", v), 32'(err), 32'(VT[v].eerr));
      chk(untrimmed == VT[v].euntr, $sformatf("R6 untrimmed v%0d", v), 32'(untrimmed), 32'(VT[v].euntr));
      chk(rc_trim_code == VT[v].erc, $sformatf("R5 rc code v%0d", v), 32'(rc_trim_code), 32'(VT[v].erc));
      chk(!mux_ready_b[sel] && src_pwr_en[sel] && sel_hold, $sformatf("R3 R4 armed v%0d", v),
          {mux_ready_b, src_pwr_en, sel_hold}, 32'h0);
      if (v == 1)
        chk(xtal_trim_code == XT_C && xtal_trim_en && xtal_trim_hold, "R9 crystal trim saved",
            {xtal_trim_code, xtal_trim_en, xtal_trim_hold}, {XT_C, 2'b11});
      @(negedge clk);
    end
    aon_rc_valid = 1'b0; fuse_rc_valid = 1'b0; xfsm_fail = 1'b0;

    chk(key_writes == 1, "R8 crystal calibration started once", key_writes, 1);
    chk(cal_starts == 1, "R5 R6 calibration requested once", cal_starts, 1);
    chk(viol_hold == 0, "R4 select moved under hold", viol_hold, 0);
    chk(viol_hop == 0, "R2 direct hop", viol_hop, 0);
    chk(viol_rdy == 0, "R3 select before ready", viol_rdy, 0);
    chk(viol_trim == 0, "R7 rc trim moved under hold", viol_trim, 0);
    chk(rc_trim_en && rc_trim_hold, "R7 rc enable and hold", {rc_trim_en, rc_trim_hold}, 2'b11);

    // R11 calibrator never answers
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cal_enable = 1'b0;
    run_req(2'b01, 1'b0);
    chk(err == 1'b1, "R11 timeout error", 32'(err), 32'd1);
    chk(sel == 2'b00 && sel_hold, "R11 select unchanged", {sel, sel_hold}, 3'b001);
    chk(rc_trim_code == 8'h00, "R11 trim unchanged", 32'(rc_trim_code), 32'h0);
    @(negedge clk);
    chk(!done && !busy, "R1 done is a single pulse", {done, busy}, 32'h0);
    summary();
  end
endmodule